// File: doc/BRIEF.md
# Clock Source Mode Controller

This controller tracks which oscillator supplies the CPU clock and carries out software requests that change that choice. It has three run statuses. In the first, only the internal ring oscillator runs and drives the CPU. In the second, the high-speed oscillator has been started but the CPU still runs from the internal one. In the third, the CPU runs from the high-speed oscillator. Software moves between statuses with one-cycle write strobes that carry the new value of an oscillator-stop bit or a clock-select bit. Each run status also has a halt substate and a stop substate, and an interrupt request leaves either one.

An internal counter measures the stabilization time of the high-speed oscillator. It counts a programmable number of cycles while the oscillator enable is high and clears whenever that enable is low. A request that breaks a transition rule leaves the state unchanged and raises a one-cycle error pulse. Examples are selecting the high-speed clock before it is stable, or stopping the oscillator while the CPU still uses it. A configuration input can keep the internal oscillator running through stop, so that a watchdog keeps counting.

The controller only makes the decisions. The glitch-free clock multiplexer and the oscillators themselves sit outside it.

Top module: `clksrc_mode_ctrl`

## Requirements
- R1: While `rst` is high, and after any cycle with `rst` high, the outputs are: `intOscEn`=1, `hsOscEn`=0, `cpuClkSel`=0, `clkStatus`=0, `halted`=0, `stopped`=0, `errPulse`=0. This holds whatever strobes are present in that cycle.
- R2: In status 1, an oscillator-stop write with value 0 enters status 2 and sets `hsOscEn`=1 after that edge. In status 2 with `clkStatus`=0, a write with value 1 returns to status 1 and sets `hsOscEn`=0.
- R3: `oscStable` goes to 1 exactly `stabLimit` clock edges after the first edge at which `hsOscEn` is high, and stays 1 while `hsOscEn` stays high. One edge after `hsOscEn` goes low, `oscStable` is 0 (when `stabLimit` is not 0).
- R4: A clock-select write with value 1 in status 2 while `oscStable`=1 enters status 3 (`cpuClkSel`=1). The same write is refused with an error pulse in status 2 while `oscStable`=0, and in status 1.
- R5: `clkStatus` equals the value `cpuClkSel` had one cycle earlier.
- R6: A clock-select write with value 0 in status 3 returns to status 2 (`cpuClkSel`=0, `hsOscEn` still 1).
- R7: An oscillator-stop write with value 1 is refused with an error pulse, and no state change, in status 3, and in status 2 while `clkStatus`=1.
- R8: A halt request from any run status sets `halted`=1 and leaves both oscillator enables unchanged. While halted, register writes have no effect and raise no error. An interrupt clears `halted` and returns to the same run status.
- R9: A stop request sets `stopped`=1 and `hsOscEn`=0. During stop, `intOscEn` equals the `keepIntOsc` input.
- R10: An interrupt during stop returns at once to status 1 or status 2 (`stopped`=0). From status 2, the high-speed clock then needs a full new stabilization time before it can be selected. When stop was entered from status 3, `hsOscEn` returns to 1 and `stopped` stays 1 until `stabLimit`+1 edges after the interrupt edge. The controller then resumes in status 3.
- R11: When several requests are present in one run cycle, only the highest one acts, in the order stop, halt, oscillator-stop write, clock-select write. The lower ones have no effect and raise no error.
- R12: `errPulse` is high for exactly the one cycle after a refused request. Writes that ask for the state the controller is already in raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, highest priority |
| wrOscStop | input | 1 | Write strobe for the oscillator-stop bit |
| oscStopVal | input | 1 | Value written to the oscillator-stop bit |
| wrClkSel | input | 1 | Write strobe for the clock-select bit |
| clkSelVal | input | 1 | Value written to the clock-select bit |
| haltReq | input | 1 | Halt entry strobe |
| stopReq | input | 1 | Stop entry strobe |
| irq | input | 1 | Interrupt request, wakes from halt and stop |
| keepIntOsc | input | 1 | Keep the internal oscillator running during stop |
| stabLimit | input | CNT_W | Stabilization time in cycles |
| intOscEn | output | 1 | Internal oscillator enable |
| hsOscEn | output | 1 | High-speed oscillator enable |
| cpuClkSel | output | 1 | CPU clock select, 1 = high-speed oscillator |
| clkStatus | output | 1 | CPU clock status flag, follows `cpuClkSel` one cycle later |
| oscStable | output | 1 | Stabilization time has elapsed |
| halted | output | 1 | Halt substate |
| stopped | output | 1 | Stop substate, including the wait for stabilization on wake |
| errPulse | output | 1 | One-cycle pulse on a refused request |

## Verification
The bench probes the stabilization boundary from both sides: a select one cycle early must be refused and the next one accepted. A counter that is off by one, or that does not clear on stop, would let the CPU switch onto an unsettled clock. It stops the oscillator in the cycle right after a return to the internal clock, while the status flag still shows the high-speed clock. A controller that checked the select bit instead of the lagging flag would cut the clock under a running handover. It also wakes from stop in status 3 and counts the edges until `stopped` falls, checks that writes made while halted have no effect, and presents several requests in one cycle. A broken priority order there would either raise a false error or carry out the wrong transition.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

  // Run status: which oscillator drives the CPU
  typedef enum logic [1:0] {
    RS_INT  = 2'd0,  // internal only, high-speed stopped
    RS_BOTH = 2'd1,  // internal drives CPU, high-speed running
    RS_HS   = 2'd2   // high-speed drives CPU
  } runState_t;

  // Low-power substate
  typedef enum logic [1:0] {
    LP_RUN  = 2'd0,
    LP_HALT = 2'd1,
    LP_STOP = 2'd2,
    LP_WAKE = 2'd3   // woken from stop in RS_HS, waiting for stabilization
  } lpMode_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic hsOn;    // high-speed oscillator currently enabled
    logic selHs;   // CPU clock select currently on high-speed
  } dpStrobe_t;

endpackage

// File: rtl/clksrc_dp.sv
module clksrc_dp
  import clksrc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        strb,
  input  logic [CNT_W-1:0] stabLimit,
  output logic             stabDone,
  output logic             clkStatus
);

  logic [CNT_W-1:0] stabCnt;

  // Stabilization counter: clears while the oscillator is off, saturates at the limit
  always_ff @(posedge clk) begin
    if (rst) begin
      stabCnt <= '0;
    end else if (!strb.hsOn) begin
      stabCnt <= '0;
    end else if (stabCnt < stabLimit) begin
      stabCnt <= stabCnt + 1'b1;
    end
  end

  assign stabDone = (stabCnt >= stabLimit);

  // Clock status flag lags the select by one cycle
  always_ff @(posedge clk) begin
    if (rst) clkStatus <= 1'b0;
    else     clkStatus <= strb.selHs;
  end

  AST_STAB_HELD: assert property (@(posedge clk) disable iff (rst)
    (strb.hsOn && $past(strb.hsOn) && $past(stabDone) && $stable(stabLimit)) |-> stabDone); // R3

  AST_STATUS_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    $rose(clkStatus) |-> $past(strb.selHs)); // R5

endmodule

// File: rtl/clksrc_fsm.sv
module clksrc_fsm
  import clksrc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wrOscStop,
  input  logic      oscStopVal,
  input  logic      wrClkSel,
  input  logic      clkSelVal,
  input  logic      haltReq,
  input  logic      stopReq,
  input  logic      irq,
  input  logic      keepIntOsc,
  input  logic      stabDone,
  input  logic      clkStatus,
  output dpStrobe_t strb,
  output logic      intOscEn,
  output logic      hsOscEn,
  output logic      cpuClkSel,
  output logic      halted,
  output logic      stopped,
  output logic      errPulse
);

  runState_t runSt, runNx;
  lpMode_t   lp, lpNx;
  logic      errNx;

  always_comb begin
    runNx = runSt;
    lpNx  = lp;
    errNx = 1'b0;
    unique case (lp)
      LP_RUN: begin
        if (stopReq) begin
          lpNx = LP_STOP;
        end else if (haltReq) begin
          lpNx = LP_HALT;
        end else if (wrOscStop) begin
          if (!oscStopVal) begin
            if (runSt == RS_INT) runNx = RS_BOTH;
          end else if (runSt == RS_HS || clkStatus) begin
            errNx = 1'b1;
          end else begin
            runNx = RS_INT;
          end
        end else if (wrClkSel) begin
          if (clkSelVal) begin
            if (runSt == RS_INT || (runSt == RS_BOTH && !stabDone)) errNx = 1'b1;
            else runNx = RS_HS;
          end else if (runSt == RS_HS) begin
            runNx = RS_BOTH;
          end
        end
      end
      LP_HALT: if (irq) lpNx = LP_RUN;
      LP_STOP: if (irq) lpNx = (runSt == RS_HS) ? LP_WAKE : LP_RUN;
      LP_WAKE: if (stabDone) lpNx = LP_RUN;
      default: lpNx = LP_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      runSt    <= RS_INT;
      lp       <= LP_RUN;
      errPulse <= 1'b0;
    end else begin
      runSt    <= runNx;
      lp       <= lpNx;
      errPulse <= errNx;
    end
  end

  assign hsOscEn    = (runSt != RS_INT) && (lp != LP_STOP);
  assign intOscEn   = (lp != LP_STOP) || keepIntOsc;
  assign cpuClkSel  = (runSt == RS_HS);
  assign halted     = (lp == LP_HALT);
  assign stopped    = (lp == LP_STOP) || (lp == LP_WAKE);
  assign strb.hsOn  = hsOscEn;
  assign strb.selHs = cpuClkSel;

  AST_SEL_AFTER_STABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(cpuClkSel) |-> $past(stabDone)); // R4

  AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
    errPulse |-> (runSt == $past(runSt)) && (lp == $past(lp))); // R7

  AST_INT_ONLY_STATUS_LOW: assert property (@(posedge clk) disable iff (rst)
    (runSt == RS_INT) |-> !clkStatus); // R2

  AST_HALT_HOLDS_RUN: assert property (@(posedge clk) disable iff (rst)
    (lp == LP_HALT && $past(lp) == LP_HALT) |-> $stable(runSt)); // R8

endmodule

// File: rtl/clksrc_mode_ctrl.sv
module clksrc_mode_ctrl
  import clksrc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrOscStop,
  input  logic             oscStopVal,
  input  logic             wrClkSel,
  input  logic             clkSelVal,
  input  logic             haltReq,
  input  logic             stopReq,
  input  logic             irq,
  input  logic             keepIntOsc,
  input  logic [CNT_W-1:0] stabLimit,
  output logic             intOscEn,
  output logic             hsOscEn,
  output logic             cpuClkSel,
  output logic             clkStatus,
  output logic             oscStable,
  output logic             halted,
  output logic             stopped,
  output logic             errPulse
);

  dpStrobe_t strb;

  clksrc_fsm u_fsm (
    .clk(clk), .rst(rst),
    .wrOscStop(wrOscStop), .oscStopVal(oscStopVal),
    .wrClkSel(wrClkSel), .clkSelVal(clkSelVal),
    .haltReq(haltReq), .stopReq(stopReq), .irq(irq),
    .keepIntOsc(keepIntOsc), .stabDone(oscStable), .clkStatus(clkStatus),
    .strb(strb), .intOscEn(intOscEn), .hsOscEn(hsOscEn),
    .cpuClkSel(cpuClkSel), .halted(halted), .stopped(stopped),
    .errPulse(errPulse)
  );

  clksrc_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .stabLimit(stabLimit),
    .stabDone(oscStable), .clkStatus(clkStatus)
  );

endmodule

// File: tb/clksrc_mode_ctrl_bench.sv
`timescale 1ns/1ps
module clksrc_mode_ctrl_bench;
  localparam int CNT_W = 8;
  localparam int LIM   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrOscStop = 0, oscStopVal = 0, wrClkSel = 0, clkSelVal = 0;
  logic haltReq = 0, stopReq = 0, irq = 0, keepIntOsc = 0;
  logic [CNT_W-1:0] stabLimit = CNT_W'(LIM);
  logic intOscEn, hsOscEn, cpuClkSel, clkStatus, oscStable, halted, stopped, errPulse;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  clksrc_mode_ctrl #(.CNT_W(CNT_W)) u_clksrc_mode_ctrl (
    .clk(clk), .rst(rst), .wrOscStop(wrOscStop), .oscStopVal(oscStopVal),
    .wrClkSel(wrClkSel), .clkSelVal(clkSelVal), .haltReq(haltReq),
    .stopReq(stopReq), .irq(irq), .keepIntOsc(keepIntOsc), .stabLimit(stabLimit),
    .intOscEn(intOscEn), .hsOscEn(hsOscEn), .cpuClkSel(cpuClkSel),
    .clkStatus(clkStatus), .oscStable(oscStable), .halted(halted),
    .stopped(stopped), .errPulse(errPulse)
  );

  task automatic chk(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Let one edge sample the current inputs, then clear all strobes at the negedge
  task automatic tick();
    @(negedge clk);
    wrOscStop = 0; wrClkSel = 0; haltReq = 0; stopReq = 0; irq = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic t_reset();
    wrOscStop = 1; oscStopVal = 0; stopReq = 1;
    tick(); tick();
    chk("R1 intOscEn", intOscEn, 1);
    chk("R1 hsOscEn", hsOscEn, 0);
    chk("R1 cpuClkSel", cpuClkSel, 0);
    chk("R1 clkStatus", clkStatus, 0);
    chk("R1 stopped", stopped, 0);
    chk("R1 halted", halted, 0);
    chk("R1 errPulse", errPulse, 0);
    rst = 0;
  endtask

  task automatic t_startAndSelect();
    wrOscStop = 1; oscStopVal = 0; tick();
    chk("R2 hsOscEn on", hsOscEn, 1);
    chk("R3 not stable yet", oscStable, 0);
    idle(LIM - 2);
    wrClkSel = 1; clkSelVal = 1; tick();
    chk("R4 early select refused err", errPulse, 1);
    chk("R4 early select no switch", cpuClkSel, 0);
    idle(1);
    chk("R3 stable at limit", oscStable, 1);
    chk("R12 err one cycle", errPulse, 0);
    wrClkSel = 1; clkSelVal = 1; tick();
    chk("R4 select accepted", cpuClkSel, 1);
    chk("R5 status lags", clkStatus, 0);
    idle(1);
    chk("R5 status follows", clkStatus, 1);
  endtask

  task automatic t_refuseStop();
    wrOscStop = 1; oscStopVal = 1; tick();
    chk("R7 stop in st3 err", errPulse, 1);
    chk("R7 stop in st3 hs kept", hsOscEn, 1);
    chk("R7 stop in st3 sel kept", cpuClkSel, 1);
    wrClkSel = 1; clkSelVal = 0; tick();
    chk("R6 back to internal", cpuClkSel, 0);
    chk("R6 hs still on", hsOscEn, 1);
    chk("R5 status still high", clkStatus, 1);
    wrOscStop = 1; oscStopVal = 1; tick();
    chk("R7 stop while status high err", errPulse, 1);
    chk("R7 stop while status high hs kept", hsOscEn, 1);
    wrOscStop = 1; oscStopVal = 1; tick();
    chk("R2 hs stopped", hsOscEn, 0);
    chk("R12 legal stop no err", errPulse, 0);
    idle(1);
    chk("R3 stable cleared", oscStable, 0);
  endtask

  task automatic t_st1Select();
    wrClkSel = 1; clkSelVal = 1; tick();
    chk("R4 select in st1 err", errPulse, 1);
    chk("R4 select in st1 no switch", cpuClkSel, 0);
    wrClkSel = 1; clkSelVal = 0; tick();
    chk("R12 no-op select no err", errPulse, 0);
    wrOscStop = 1; oscStopVal = 1; tick();
    chk("R12 no-op stop no err", errPulse, 0);
  endtask

  task automatic t_halt();
    wrOscStop = 1; oscStopVal = 0; tick();
    haltReq = 1; tick();
    chk("R8 halted", halted, 1);
    chk("R8 hs kept", hsOscEn, 1);
    chk("R8 int kept", intOscEn, 1);
    wrOscStop = 1; oscStopVal = 1; tick();
    chk("R8 write ignored hs", hsOscEn, 1);
    chk("R8 write ignored err", errPulse, 0);
    irq = 1; tick();
    chk("R8 woke", halted, 0);
    chk("R8 same status hs", hsOscEn, 1);
    chk("R8 same status sel", cpuClkSel, 0);
  endtask

  task automatic t_stopFromSt2();
    keepIntOsc = 0;
    stopReq = 1; tick();
    chk("R9 stopped", stopped, 1);
    chk("R9 hs off", hsOscEn, 0);
    chk("R9 int off", intOscEn, 0);
    keepIntOsc = 1; idle(1);
    chk("R9 int kept by option", intOscEn, 1);
    irq = 1; tick();
    chk("R10 st2 wake immediate", stopped, 0);
    chk("R10 hs back on", hsOscEn, 1);
    chk("R10 stable restarted", oscStable, 0);
    idle(LIM - 1);
    wrClkSel = 1; clkSelVal = 1; tick();
    chk("R10 select before restab err", errPulse, 1);
    wrClkSel = 1; clkSelVal = 1; tick();
    chk("R10 select after restab", cpuClkSel, 1);
    idle(1);
  endtask

  task automatic t_stopFromSt3();
    stopReq = 1; wrOscStop = 1; oscStopVal = 1; tick();
    chk("R11 stop wins", stopped, 1);
    chk("R11 no err", errPulse, 0);
    chk("R9 hs off st3", hsOscEn, 0);
    chk("R9 int kept", intOscEn, 1);
    irq = 1; tick();
    chk("R10 hs restart", hsOscEn, 1);
    chk("R10 still stopped", stopped, 1);
    idle(LIM);
    chk("R10 waiting", stopped, 1);
    idle(1);
    chk("R10 resumed", stopped, 0);
    chk("R10 on hs", cpuClkSel, 1);
    chk("R10 status hs", clkStatus, 1);
  endtask

  task automatic t_priority();
    haltReq = 1; wrClkSel = 1; clkSelVal = 0; tick();
    chk("R11 halt wins", halted, 1);
    chk("R11 select dropped", cpuClkSel, 1);
    irq = 1; tick();
    wrOscStop = 1; oscStopVal = 0; wrClkSel = 1; clkSelVal = 0; tick();
    chk("R11 oscstop wins", cpuClkSel, 1);
    chk("R11 no err", errPulse, 0);
  endtask

  task automatic t_resetMid();
    rst = 1; stopReq = 1; tick();
    chk("R1 mid reset sel", cpuClkSel, 0);
    chk("R1 mid reset hs", hsOscEn, 0);
    chk("R1 mid reset stopped", stopped, 0);
    rst = 0; idle(1);
    chk("R1 status cleared", clkStatus, 0);
  endtask

  initial begin
    t_reset();
    t_startAndSelect();
    t_refuseStop();
    t_st1Select();
    t_halt();
    t_stopFromSt2();
    t_stopFromSt3();
    t_priority();
    t_resetMid();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog R1..all act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule